// File: doc/BRIEF.md
# Shared Bus Grant Arbiter with Serial and Parallel Schemes

This block decides which of several bus masters, for example a processor and a few DMA engines, may drive a shared bus. A mode input picks one of two arbitration schemes. In the serial scheme, every master's request folds into one common request line. The arbiter then launches a single grant into position 0, and that grant travels from device to device. A device that is not asking for the bus hands the grant to its neighbour. In the parallel scheme, every master has its own request and its own grant. A central priority picker looks at all requests together.

Ownership is sticky. The winning master keeps its grant for as long as it holds its request high, whatever the other masters do and whatever happens to the mode input. A new decision is made only while nobody owns the bus. Because of this, the bus is always idle for exactly one cycle between two owners. A busy flag and the owner's index are provided as outputs. So is the grant as each chain position sees it, which shows how far the serial grant travelled.

Top module: `bus_arbiter`

## Requirements
- R1: While `rst_n` is low, with reset synchronous, `gnt_o`, `busy_o`, `owner_o` and `chain_seen_o` are all zero whatever the requests are. They are zero again in the cycle after the first rising edge that samples reset.
- R2: At most one bit of `gnt_o` is set in any cycle.
- R3: With `daisy_mode_i` = 0 and the bus idle, a nonzero `req_i` sampled at a rising edge grants, from the next cycle on, the lowest-numbered requesting master. Bit 0 has the highest priority.
- R4: With `daisy_mode_i` = 1, the bus idle and at least one request set, `chain_seen_o[i]` is 1 for every position from 0 up to and including the first requesting position, and 0 beyond it. This is combinational in the same cycle.
- R5: In serial mode, a device that sees the grant without requesting passes it on, so the grant taken at the next edge belongs to the first requesting position.
- R6: While the owner keeps its request high, `gnt_o` does not change, even if a higher-priority master requests.
- R7: When the owner's request is sampled low, `gnt_o` is all zero in the next cycle, even if others are requesting. A new owner can appear at the earliest one cycle later.
- R8: `busy_o` is 1 exactly when a grant is active. While busy, `owner_o` is the index of the granted master; while idle, it is 0.
- R9: Changing `daisy_mode_i` while the bus is held does not affect the current owner. The new mode applies at the next decision.
- R10: `chain_seen_o` is all zero while the bus is busy, in parallel mode, or when no master requests. With no requests, no grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| daisy_mode_i | input | 1 | 1 = serial grant chain, 0 = parallel request/grant |
| req_i | input | NUM_MASTERS | Per-master bus request, bit i from master i |
| gnt_o | output | NUM_MASTERS | Registered per-master grant, one-hot or zero |
| chain_seen_o | output | NUM_MASTERS | Serial grant as it reaches each chain position |
| owner_o | output | $clog2(NUM_MASTERS) | Index of the current owner, 0 when idle |
| busy_o | output | 1 | Bus held by some master |

## Verification
The hardest situations to reach come from several events landing on the same edge. One is an owner releasing in the same cycle that other masters request. Another is a mode flip during a long hold. A third is a higher-priority request arriving while a lower master owns the bus. Directed sequences build each of these on purpose. After that, a seeded random phase mostly keeps the previous request pattern, so that holds last several cycles, and flips the mode at random. Every cycle is compared with a bench model of owner, grant and chain reach.

// File: rtl/arb_pkg.sv
// Package: shared types for the bus arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package arb_pkg;
    // Arbitration scheme selected by the mode input.
    typedef enum logic {
        ARB_PARALLEL = 1'b0,
        ARB_SERIAL   = 1'b1
    } arb_mode_e;
endpackage

// File: rtl/arb_daisy_chain.sv
// Module: serial grant ripple across all positions.
// The grant enters position 0. A position that is not requesting passes
// it on; the first requesting position absorbs it.
// Assumes: drive_i is already gated by mode, idle and shared request.
module arb_daisy_chain #(
    parameter int NUM_MASTERS = 4
) (
    input  logic                   drive_i,
    input  logic [NUM_MASTERS-1:0] req_i,
    output logic [NUM_MASTERS-1:0] seen_o,
    output logic [NUM_MASTERS-1:0] take_o
);

    // Ripple the grant position by position.
    always_comb begin
        logic carry;
        carry = drive_i;
        for (int i = 0; i < NUM_MASTERS; i++) begin
            seen_o[i] = carry;
            take_o[i] = carry & req_i[i];
            carry     = carry & ~req_i[i];
        end
    end

endmodule

// File: rtl/arb_prio_pick.sv
// Module: fixed-priority picker for the parallel scheme; bit 0 wins.
// Assumes: en_i already includes mode and idle gating.
module arb_prio_pick #(
    parameter int NUM_MASTERS = 4
) (
    input  logic                   en_i,
    input  logic [NUM_MASTERS-1:0] req_i,
    output logic [NUM_MASTERS-1:0] pick_o
);

    logic [NUM_MASTERS:0] blocked;

    assign blocked[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < NUM_MASTERS; g++) begin : g_pick
            // A request is blocked by any lower-numbered request.
            assign blocked[g+1] = blocked[g] | req_i[g];
            assign pick_o[g]    = en_i & req_i[g] & ~blocked[g];
        end
    endgenerate

endmodule

// File: rtl/arb_owner_slot.sv
// Module: per-master ownership flop.
// The slot is set by a take pulse and held while the master keeps
// requesting; it clears when the request is sampled low.
// Assumes: take_i can only pulse while no slot is owned.
module arb_owner_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic req_i,
    output logic owned_o
);

    // Capture or hold ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owned_o <= 1'b0;
        end else if (owned_o) begin
            owned_o <= req_i;
        end else begin
            owned_o <= take_i;
        end
    end

endmodule

// File: rtl/bus_arbiter.sv
// Module: shared-bus arbiter with a serial (chained) or parallel scheme.
// It makes a decision only while the bus is idle; the owner keeps its grant
// until its request drops, which leaves one idle cycle between owners.
// Assumes: requests are synchronous to clk; reset is synchronous and active low.
module bus_arbiter #(
    parameter int NUM_MASTERS = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                daisy_mode_i,
    input  logic [NUM_MASTERS-1:0]              req_i,
    output logic [NUM_MASTERS-1:0]              gnt_o,
    output logic [NUM_MASTERS-1:0]              chain_seen_o,
    output logic [$clog2(NUM_MASTERS)-1:0]      owner_o,
    output logic                                busy_o
);
    import arb_pkg::*;

    localparam int IDW = $clog2(NUM_MASTERS);

    arb_mode_e              mode;
    logic                   shared_req;
    logic                   idle_ok;
    logic                   chain_drive;
    logic [NUM_MASTERS-1:0] chain_take;
    logic [NUM_MASTERS-1:0] pick;
    logic [NUM_MASTERS-1:0] take;
    logic [NUM_MASTERS-1:0] owned;
    logic [IDW-1:0]         owner_idx;

    // Decode the mode and form the shared request line.
    assign mode       = arb_mode_e'(daisy_mode_i);
    assign shared_req = |req_i;
    assign idle_ok    = rst_n & ~busy_o;
    assign chain_drive = idle_ok & shared_req & (mode == ARB_SERIAL);

    arb_daisy_chain #(.NUM_MASTERS(NUM_MASTERS)) u_chain (
        .drive_i (chain_drive),
        .req_i   (req_i),
        .seen_o  (chain_seen_o),
        .take_o  (chain_take)
    );

    arb_prio_pick #(.NUM_MASTERS(NUM_MASTERS)) u_pick (
        .en_i   (idle_ok & (mode == ARB_PARALLEL)),
        .req_i  (req_i),
        .pick_o (pick)
    );

    // Merge the two schemes; only one of them is enabled at a time.
    assign take = chain_take | pick;

    genvar g;
    generate
        for (g = 0; g < NUM_MASTERS; g++) begin : g_slot
            arb_owner_slot u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .take_i  (take[g]),
                .req_i   (req_i[g]),
                .owned_o (owned[g])
            );
        end
    endgenerate

    // Encode the one-hot owner into an index.
    always_comb begin
        owner_idx = '0;
        for (int i = 0; i < NUM_MASTERS; i++) begin
            if (owned[i]) owner_idx = owner_idx | IDW'(i);
        end
    end

    assign gnt_o   = owned;
    assign busy_o  = |owned;
    assign owner_o = owner_idx;

endmodule

// File: rtl/bus_arbiter_chk.sv
// Module: assertion checker bound to bus_arbiter.
// Assumes: the same parameters as the bound instance.
module bus_arbiter_chk #(
    parameter int NUM_MASTERS = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           daisy_mode_i,
    input logic [NUM_MASTERS-1:0]         req_i,
    input logic [NUM_MASTERS-1:0]         gnt_o,
    input logic [NUM_MASTERS-1:0]         chain_seen_o,
    input logic [$clog2(NUM_MASTERS)-1:0] owner_o,
    input logic                           busy_o
);

    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    assert_parallel_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && (|req_i) && !daisy_mode_i) |=>
        (gnt_o == ($past(req_i) & (~$past(req_i) + 1'b1))));

    assert_serial_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && (|req_i) && daisy_mode_i) |=>
        (gnt_o == ($past(req_i) & (~$past(req_i) + 1'b1))));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && req_i[owner_o]) |=> $stable(gnt_o));

    assert_release_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !req_i[owner_o]) |=> (gnt_o == '0));

    assert_owner_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> gnt_o[owner_o]);

    assert_idle_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (owner_o == '0));

    assert_chain_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o || !daisy_mode_i || (req_i == '0)) |-> (chain_seen_o == '0));

    assert_chain_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && daisy_mode_i && (|req_i)) |-> chain_seen_o[0]);

endmodule

bind bus_arbiter bus_arbiter_chk #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .daisy_mode_i (daisy_mode_i),
    .req_i        (req_i),
    .gnt_o        (gnt_o),
    .chain_seen_o (chain_seen_o),
    .owner_o      (owner_o),
    .busy_o       (busy_o)
);

// File: tb/bus_arbiter_bench.sv
module bus_arbiter_bench;
    localparam int N   = 4;
    localparam int IDW = $clog2(N);
    localparam int HALF = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] gnt, seen;
    logic [IDW-1:0] owner;
    logic         busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Bench model state.
    bit           exp_busy = 0;
    int           exp_owner = 0;

    always #HALF clk = ~clk;

    bus_arbiter #(.NUM_MASTERS(N)) u_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .daisy_mode_i(mode), .req_i(req),
        .gnt_o(gnt), .chain_seen_o(seen), .owner_o(owner), .busy_o(busy)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int lowest(input logic [N-1:0] r);
        for (int i = 0; i < N; i++) if (r[i]) return i;
        return -1;
    endfunction

    // Positions the serial grant reaches: up to and including first requester.
    function automatic logic [N-1:0] exp_seen(input logic m, input logic [N-1:0] r, input bit b);
        logic [N-1:0] s;
        s = '0;
        if (m && !b && (r != '0)) begin
            for (int i = 0; i < N; i++) begin
                s[i] = 1'b1;
                if (r[i]) break;
            end
        end
        return s;
    endfunction

    // One cycle: apply inputs, check chain, step model, check registered outputs.
    task automatic step(input logic m, input logic [N-1:0] r, input string tag);
        @(negedge clk);
        mode = m;
        req  = r;
        #1;
        chk(tag, "chain_seen", int'(seen), int'(exp_seen(m, r, exp_busy)));
        @(posedge clk);
        if (exp_busy) begin
            if (!r[exp_owner]) exp_busy = 0;
        end else if (r != '0) begin
            exp_busy  = 1;
            exp_owner = lowest(r);
        end
        #5;
        chk(tag, "gnt", int'(gnt), exp_busy ? (1 << exp_owner) : 0);
        chk(tag, "busy", int'(busy), int'(exp_busy));
        chk(tag, "owner", int'(owner), exp_busy ? exp_owner : 0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(2 * HALF * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [N-1:0] r;
        logic m;
        void'($urandom(32'h5eed_0042));

        // R1: reset holds everything at zero, even with requests in serial mode.
        mode = 1'b1;
        req  = '1;
        repeat (3) @(posedge clk);
        #5;
        chk("R1", "gnt", int'(gnt), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "owner", int'(owner), 0);
        chk("R1", "chain_seen", int'(seen), 0);
        @(negedge clk);
        req   = '0;
        rst_n = 1'b1;

        // R10: no request gives no grant in either mode.
        step(1'b0, 4'b0000, "R10");
        step(1'b1, 4'b0000, "R10");

        // R3: parallel picks lowest; hold then release.
        step(1'b0, 4'b1010, "R3");
        // R6: a higher-priority request cannot steal the bus.
        step(1'b0, 4'b1011, "R6");
        step(1'b0, 4'b0111, "R6");
        // R7: owner drops while others request; one idle cycle follows.
        step(1'b0, 4'b0101, "R7");
        step(1'b0, 4'b0101, "R7");
        step(1'b0, 4'b0000, "R7");
        step(1'b0, 4'b0000, "R8");

        // R4 and R5: serial grant passes non-requesting positions.
        step(1'b1, 4'b1000, "R4");
        step(1'b1, 4'b0000, "R7");
        step(1'b1, 4'b0100, "R5");
        // R9: mode flips while held; owner stays.
        step(1'b0, 4'b0111, "R9");
        step(1'b1, 4'b0101, "R9");
        step(1'b1, 4'b0001, "R9");
        step(1'b0, 4'b0011, "R9");
        step(1'b0, 4'b0010, "R8");
        step(1'b0, 4'b0000, "R7");

        // Random phase: mostly keep the previous pattern so holds last.
        r = '0;
        for (int k = 0; k < 400; k++) begin
            if (($urandom % 4) == 0) r = N'($urandom);
            if (($urandom % 8) == 0) r = '0;
            m = (($urandom % 5) == 0) ? ~mode : mode;
            step(m, r, "R2");
        end

        summary();
        $finish;
    end
endmodule